// File: doc/BRIEF.md
# Multicycle 32-bit Datapath

This block is the datapath half of a multicycle processor core for a small load/store instruction set. It covers register-format ALU operations, word load, word store, branch-on-equal and jump. Each instruction runs as a series of short steps, and each step uses at most one major resource. One memory holds both code and data. One ALU does all the arithmetic, including the program-counter increment and the branch-target sum. Hidden holding registers carry values from one step to the next: the instruction register, the memory data register, the two operand latches and the ALU result latch.

A separate control sequencer drives every select and write enable from one cycle to the next. The datapath returns the opcode of the held instruction and a combinational ALU zero flag to that sequencer. The current program counter and the latched ALU result are also brought out, so the sequencer or a test harness can see progress. The memory is a word-addressed array with a byte-address interface. At reset it is filled from a parameter image. The register file has 32 entries, and entry 0 is fixed at zero.

Top module: `mc_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, all holding registers and the register file clear to zero, and the memory reloads its parameter image. After reset, `pc`, `alu_q` and `opcode` read 0.
- R2: A fetch step loads the instruction register from memory. That step has `iord`=0, `ir_we`=1, `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_ctl`=010 (add), `pc_src`=00 (live ALU result) and `pc_we`=1. The memory word index is the byte address divided by 4. After the edge, `pc` equals the old PC plus 4 and `opcode` equals bits 31:26 of the fetched word.
- R3: The instruction register changes only when `ir_we` is 1. The program counter changes only when `pc_we` or `pc_we_cond` is 1.
- R4: On every clock edge, operand latch A loads register[IR[25:21]] and operand latch B loads register[IR[20:16]]. With `alu_a_sel`=0 and `alu_b_sel`=11, the ALU result latch gets PC plus the sign-extended IR[15:0] shifted left by 2.
- R5: The ALU codes on `alu_ctl` are 000 AND, 001 OR, 010 add, 110 subtract and 111 signed set-less-than. The result is latched into `alu_q` at every edge. `zero` is 1 exactly when the present ALU result is 0.
- R6: With `reg_we`=1, `reg_dst`=1 and `mem_to_reg`=0, the register indexed by IR[15:11] takes `alu_q`.
- R7: With `alu_a_sel`=1 and `alu_b_sel`=10, the ALU forms A plus the sign-extended IR[15:0]. A following step with `iord`=1 reads that address into the memory data register. A step after that with `reg_we`=1, `reg_dst`=0 and `mem_to_reg`=1 writes the data to the register indexed by IR[20:16].
- R8: With `iord`=1 and `mem_we`=1, the word at address `alu_q` takes the value of latch B.
- R9: With `pc_we_cond`=1, `pc_we`=0 and `pc_src`=01, the PC loads `alu_q` when `zero` is 1 and holds when `zero` is 0.
- R10: With `pc_we`=1 and `pc_src`=10, the PC loads {PC[31:28], IR[25:0], 2'b00}.
- R11: Register 0 always reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | Unconditional PC write |
| pc_we_cond | input | 1 | PC write gated by the zero flag |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU result latch |
| mem_we | input | 1 | Memory write enable |
| ir_we | input | 1 | Instruction register write enable |
| reg_we | input | 1 | Register file write enable |
| reg_dst | input | 1 | Destination select: 0 IR[20:16], 1 IR[15:11] |
| mem_to_reg | input | 1 | Write-data select: 0 ALU latch, 1 memory data register |
| alu_a_sel | input | 1 | ALU A select: 0 PC, 1 latch A |
| alu_b_sel | input | 2 | ALU B select: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| pc_src | input | 2 | PC source: 00 ALU result, 01 ALU latch, 10 jump target |
| alu_ctl | input | 3 | ALU operation code |
| opcode | output | 6 | IR[31:26] to the sequencer |
| zero | output | 1 | Present ALU result equals zero |
| pc | output | 32 | Program counter |
| alu_q | output | 32 | ALU result latch |

## Verification
Most datapath state is hidden. A wrong hidden value therefore shows up at the ports only after a step that routes it to the ALU result latch or to the PC. A bad operand latch or a bad register write appears one edge after a probe instruction adds that register to register 0. A bad branch-target sum or jump splice shows on `pc` right after the execute step. A lost memory write appears three steps after the load that reads the same word back. A broken zero flag is visible during the branch step, before its edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RAW    = $clog2(NREG);

    typedef enum logic [1:0] {
        SRCB_REG    = 2'b00,
        SRCB_FOUR   = 2'b01,
        SRCB_IMM    = 2'b10,
        SRCB_IMM_SH = 2'b11
    } srcb_e;

    typedef enum logic [1:0] {
        PCN_ALU   = 2'b00,
        PCN_LATCH = 2'b01,
        PCN_JUMP  = 2'b10,
        PCN_RSVD  = 2'b11
    } pcsel_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } aluop_e;

    typedef struct packed {
        logic [5:0]     op;
        logic [RAW-1:0] rs;
        logic [RAW-1:0] rt;
        logic [RAW-1:0] rd;
        logic [15:0]    imm;
        logic [25:0]    target;
    } fields_t;

    function automatic fields_t split_ir(input logic [XLEN-1:0] w);
        fields_t f;
        f.op     = w[31:26];
        f.rs     = w[25:21];
        f.rt     = w[20:16];
        f.rd     = w[15:11];
        f.imm    = w[15:0];
        f.target = w[25:0];
        return f;
    endfunction

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [2:0]      ctl,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        case (aluop_e'(ctl))
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [1:NREG-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/mc_memory.sv
module mc_memory
    import mc_pkg::*;
#(
    parameter int WORDS      = 64,
    parameter int INIT_WORDS = 32,
    parameter logic [INIT_WORDS*XLEN-1:0] INIT_IMAGE = '0,
    localparam int IDX_W     = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             we,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata
);

    logic [XLEN-1:0] mem    [WORDS];
    logic [XLEN-1:0] init_w [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_init
        if (g < INIT_WORDS) begin : g_img
            assign init_w[g] = INIT_IMAGE[g*XLEN +: XLEN];
        end else begin : g_zero
            assign init_w[g] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= init_w[i];
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS  = 64,
    parameter int INIT_WORDS = 32,
    parameter logic [INIT_WORDS*32-1:0] INIT_IMAGE = '0,
    localparam int IDX_W     = $clog2(MEM_WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pc_we,
    input  logic        pc_we_cond,
    input  logic        iord,
    input  logic        mem_we,
    input  logic        ir_we,
    input  logic        reg_we,
    input  logic        reg_dst,
    input  logic        mem_to_reg,
    input  logic        alu_a_sel,
    input  logic [1:0]  alu_b_sel,
    input  logic [1:0]  pc_src,
    input  logic [2:0]  alu_ctl,
    output logic [5:0]  opcode,
    output logic        zero,
    output logic [31:0] pc,
    output logic [31:0] alu_q
);

    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
    logic [XLEN-1:0] mem_rdata, rd1, rd2;
    logic [XLEN-1:0] op_a, op_b, alu_y, pc_next, wdata_rf, imm_x;
    logic [IDX_W-1:0] mem_idx;
    logic [RAW-1:0]   waddr_rf;
    fields_t          f;

    assign f     = split_ir(ir_q);
    assign imm_x = sext16(f.imm);

    // shared memory port: one address mux for fetch and data
    assign mem_idx = iord ? aluout_q[IDX_W+1:2] : pc_q[IDX_W+1:2];

    mc_memory #(
        .WORDS      (MEM_WORDS),
        .INIT_WORDS (INIT_WORDS),
        .INIT_IMAGE (INIT_IMAGE)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .idx   (mem_idx),
        .we    (mem_we),
        .wdata (b_q),
        .rdata (mem_rdata)
    );

    assign waddr_rf = reg_dst ? f.rd : f.rt;
    assign wdata_rf = mem_to_reg ? mdr_q : aluout_q;

    mc_regfile u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (f.rs),
        .ra2 (f.rt),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (reg_we),
        .wa  (waddr_rf),
        .wd  (wdata_rf)
    );

    assign op_a = alu_a_sel ? a_q : pc_q;

    always_comb begin
        case (srcb_e'(alu_b_sel))
            SRCB_REG:    op_b = b_q;
            SRCB_FOUR:   op_b = 32'd4;
            SRCB_IMM:    op_b = imm_x;
            default:     op_b = imm_x << 2;
        endcase
    end

    mc_alu u_alu (
        .a    (op_a),
        .b    (op_b),
        .ctl  (alu_ctl),
        .y    (alu_y),
        .zero (zero)
    );

    always_comb begin
        case (pcsel_e'(pc_src))
            PCN_LATCH: pc_next = aluout_q;
            PCN_JUMP:  pc_next = {pc_q[31:28], f.target, 2'b00};
            default:   pc_next = alu_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            mdr_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
        end else begin
            if (ir_we) ir_q <= mem_rdata;
            mdr_q    <= mem_rdata;
            a_q      <= rd1;
            b_q      <= rd2;
            aluout_q <= alu_y;
            if (pc_we || (pc_we_cond && zero)) pc_q <= pc_next;
        end
    end

    assign opcode = f.op;
    assign pc     = pc_q;
    assign alu_q  = aluout_q;

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ir_we |=> $stable(ir_q)); // R3

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pc_we && !pc_we_cond) |=> $stable(pc_q)); // R3

    AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (pc_we_cond && !pc_we && !zero) |=> $stable(pc_q)); // R9

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(ir_q[25:21]) == 5'd0) |-> (a_q == '0)); // R11

endmodule

// File: tb/mc_datapath_tb.sv
`timescale 1ns/100ps
module mc_datapath_tb;

    typedef struct packed {
        logic       pc_we, pc_we_cond, iord, mem_we, ir_we, reg_we, reg_dst, mem_to_reg, alu_a_sel;
        logic [1:0] b_sel, pc_src;
        logic [2:0] op;
    } ctl_t;

    typedef struct {
        int          sel;   // 0 pc, 1 alu_q, 2 opcode, 3 zero
        logic [31:0] exp;
        string       tag;
    } item_t;

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] t);
        return {6'h02, t};
    endfunction

    function automatic logic [1023:0] build_image();
        logic [1023:0] m;
        m = '0;
        m[0*32  +: 32] = enc_i(6'h23, 0, 1, 16'd112);
        m[1*32  +: 32] = enc_i(6'h23, 0, 2, 16'd116);
        m[2*32  +: 32] = enc_r(1, 2, 3);
        m[3*32  +: 32] = enc_r(1, 2, 4);
        m[4*32  +: 32] = enc_r(2, 1, 5);
        m[5*32  +: 32] = enc_r(1, 2, 6);
        m[6*32  +: 32] = enc_r(1, 2, 7);
        m[7*32  +: 32] = enc_i(6'h2b, 0, 4, 16'd124);
        m[8*32  +: 32] = enc_i(6'h23, 0, 8, 16'd124);
        m[9*32  +: 32] = enc_r(1, 1, 0);
        m[10*32 +: 32] = enc_i(6'h3f, 3, 0, 16'd0);
        m[11*32 +: 32] = enc_i(6'h3f, 4, 0, 16'd0);
        m[12*32 +: 32] = enc_i(6'h3f, 5, 0, 16'd0);
        m[13*32 +: 32] = enc_i(6'h3f, 6, 0, 16'd0);
        m[14*32 +: 32] = enc_i(6'h3f, 7, 0, 16'd0);
        m[15*32 +: 32] = enc_i(6'h3f, 8, 0, 16'd0);
        m[16*32 +: 32] = enc_i(6'h3f, 0, 0, 16'd0);
        m[17*32 +: 32] = enc_i(6'h04, 1, 2, 16'd5);
        m[18*32 +: 32] = enc_i(6'h04, 4, 8, 16'd2);
        m[19*32 +: 32] = enc_i(6'h3f, 1, 0, 16'd0);
        m[20*32 +: 32] = enc_i(6'h3f, 1, 0, 16'd0);
        m[21*32 +: 32] = enc_j(26'd24);
        m[22*32 +: 32] = enc_i(6'h3f, 1, 0, 16'd0);
        m[23*32 +: 32] = enc_i(6'h3f, 1, 0, 16'd0);
        m[24*32 +: 32] = enc_i(6'h23, 0, 9, 16'd120);
        m[25*32 +: 32] = enc_i(6'h3f, 9, 0, 16'd0);
        m[26*32 +: 32] = enc_i(6'h04, 0, 0, 16'hfffd);
        m[28*32 +: 32] = 32'd5;
        m[29*32 +: 32] = 32'hffff_fff9;
        m[30*32 +: 32] = 32'h1234_5678;
        return m;
    endfunction

    localparam logic [1023:0] PROG = build_image();

    logic        clk = 1'b0;
    logic        rst;
    logic        pc_we, pc_we_cond, iord, mem_we, ir_we, reg_we, reg_dst, mem_to_reg, alu_a_sel;
    logic [1:0]  alu_b_sel, pc_src;
    logic [2:0]  alu_ctl;
    logic [5:0]  opcode;
    logic        zero;
    logic [31:0] pc, alu_q;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    item_t q[$];
    logic [31:0] epc;

    always #2.5 clk = ~clk;

    mc_datapath #(
        .MEM_WORDS  (64),
        .INIT_WORDS (32),
        .INIT_IMAGE (PROG)
    ) u_dut (
        .clk (clk), .rst (rst),
        .pc_we (pc_we), .pc_we_cond (pc_we_cond), .iord (iord), .mem_we (mem_we),
        .ir_we (ir_we), .reg_we (reg_we), .reg_dst (reg_dst), .mem_to_reg (mem_to_reg),
        .alu_a_sel (alu_a_sel), .alu_b_sel (alu_b_sel), .pc_src (pc_src), .alu_ctl (alu_ctl),
        .opcode (opcode), .zero (zero), .pc (pc), .alu_q (alu_q)
    );

    // monitor: drains the scoreboard queue at mid-phase times
    initial begin
        forever begin
            @(clk);
            #1.5;
            while (q.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    0:       act = pc;
                    1:       act = alu_q;
                    2:       act = {26'd0, opcode};
                    default: act = {31'd0, zero};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic ctl_t mk(input logic a_sel, input logic [1:0] bs, input logic [2:0] op);
        ctl_t c;
        c = '0;
        c.alu_a_sel = a_sel;
        c.b_sel     = bs;
        c.op        = op;
        return c;
    endfunction

    task automatic expect_v(input int sel, input logic [31:0] v, input string tag);
        item_t it;
        it.sel = sel; it.exp = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic drive(input ctl_t c);
        @(negedge clk);
        pc_we = c.pc_we; pc_we_cond = c.pc_we_cond; iord = c.iord; mem_we = c.mem_we;
        ir_we = c.ir_we; reg_we = c.reg_we; reg_dst = c.reg_dst; mem_to_reg = c.mem_to_reg;
        alu_a_sel = c.alu_a_sel; alu_b_sel = c.b_sel; pc_src = c.pc_src; alu_ctl = c.op;
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    task automatic cyc(input ctl_t c);
        drive(c);
        edge_wait();
    endtask

    function automatic logic [31:0] word_at(input int k);
        return PROG[k*32 +: 32];
    endfunction

    // fetch plus decode of the word at the current expected PC
    task automatic fetch_decode();
        ctl_t c;
        logic [31:0] w;
        w = word_at(int'(epc >> 2));
        c = mk(1'b0, 2'b01, 3'b010);
        c.ir_we = 1'b1; c.pc_we = 1'b1; c.pc_src = 2'b00;
        cyc(c);
        epc = epc + 32'd4;
        expect_v(0, epc, "R2 fetch pc");
        expect_v(2, {26'd0, w[31:26]}, "R2 opcode");
        cyc(mk(1'b0, 2'b11, 3'b010));
        expect_v(1, epc + ({{16{w[15]}}, w[15:0]} << 2), "R4 branch target");
        expect_v(0, epc, "R3 pc hold");
    endtask

    task automatic do_load(input logic [31:0] addr);
        ctl_t c;
        fetch_decode();
        cyc(mk(1'b1, 2'b10, 3'b010));
        expect_v(1, addr, "R7 load address");
        c = '0; c.iord = 1'b1;
        cyc(c);
        c = '0; c.reg_we = 1'b1; c.mem_to_reg = 1'b1;
        cyc(c);
    endtask

    task automatic do_store(input logic [31:0] addr);
        ctl_t c;
        fetch_decode();
        cyc(mk(1'b1, 2'b10, 3'b010));
        expect_v(1, addr, "R8 store address");
        c = '0; c.iord = 1'b1; c.mem_we = 1'b1;
        cyc(c);
    endtask

    task automatic do_rtype(input logic [2:0] op, input logic [31:0] res, input string tag);
        ctl_t c;
        fetch_decode();
        cyc(mk(1'b1, 2'b00, op));
        expect_v(1, res, tag);
        c = '0; c.reg_we = 1'b1; c.reg_dst = 1'b1;
        cyc(c);
    endtask

    task automatic do_probe(input logic [31:0] val, input logic [5:0] op, input string tag);
        fetch_decode();
        cyc(mk(1'b1, 2'b00, 3'b010));
        expect_v(1, val, tag);
        expect_v(2, {26'd0, op}, "R3 ir hold");
    endtask

    task automatic do_branch(input logic taken, input logic [31:0] tgt);
        ctl_t c;
        fetch_decode();
        c = mk(1'b1, 2'b00, 3'b110);
        c.pc_we_cond = 1'b1; c.pc_src = 2'b01;
        drive(c);
        #1;
        expect_v(3, {31'd0, taken}, "R9 zero flag");
        edge_wait();
        if (taken) epc = tgt;
        expect_v(0, epc, taken ? "R9 branch taken" : "R9 branch not taken");
    endtask

    initial begin
        ctl_t c;
        c = '0;
        rst = 1'b1;
        drive(c);
        repeat (3) @(posedge clk);
        #1;
        expect_v(0, 32'd0, "R1 reset pc");
        expect_v(1, 32'd0, "R1 reset alu_q");
        expect_v(2, 32'd0, "R1 reset opcode");
        @(negedge clk);
        rst = 1'b0;
        epc = 32'd0;

        do_load(32'd112);                                     // r1 = 5
        do_load(32'd116);                                     // r2 = -7
        do_rtype(3'b010, 32'hffff_fffe, "R5 add");            // r3
        do_rtype(3'b110, 32'd12,        "R5 sub");            // r4
        do_rtype(3'b111, 32'd1,         "R5 slt signed");     // r5
        do_rtype(3'b000, 32'd1,         "R5 and");            // r6
        do_rtype(3'b001, 32'hffff_fffd, "R5 or");             // r7
        do_store(32'd124);                                    // mem[31] = r4
        do_load(32'd124);                                     // r8 = mem[31]
        do_rtype(3'b010, 32'd10,        "R5 add to r0");      // r0 target, discarded

        do_probe(32'hffff_fffe, 6'h3f, "R6 r3 written");
        do_probe(32'd12,        6'h3f, "R6 r4 written");
        do_probe(32'd1,         6'h3f, "R6 r5 written");
        do_probe(32'd1,         6'h3f, "R6 r6 written");
        do_probe(32'hffff_fffd, 6'h3f, "R6 r7 written");
        do_probe(32'd12,        6'h3f, "R8 stored word reloaded");
        do_probe(32'd0,         6'h3f, "R11 r0 write discarded");

        do_branch(1'b0, 32'd0);
        do_branch(1'b1, 32'd84);

        fetch_decode();
        c = '0; c.pc_we = 1'b1; c.pc_src = 2'b10;
        cyc(c);
        epc = 32'd96;
        expect_v(0, epc, "R10 jump target");

        do_load(32'd120);
        do_probe(32'h1234_5678, 6'h3f, "R7 loaded word");

        do_branch(1'b1, 32'd96);                              // backward, negative offset

        #3;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule